// File: doc/BRIEF.md
# Address-Range Bank Select Decoder

This block turns a 32-bit local address into one of five bank chip selects. Each bank owns an inclusive address window given by a start and an end bound. Both bounds are held at 1 MB granularity, so the start bound covers the low 20 address bits as zeros and the end bound covers them as ones. Each bank also has an enable bit and a device kind. A single register write port loads one whole bank entry per cycle. A lookup port compares the address against every bank in parallel and registers the outcome one cycle later: a one-hot chip select, the winning bank number, its device kind, a miss flag and an overlap flag.

Bank 0 is the boot device. It comes out of reset enabled as ROM over the top 2 MB of the address space, and its device kind cannot be changed. Banks 1 to 4 come out of reset disabled, and software picks their kind at run time. A window may span at most 512 MB. A window that is larger than this, or whose bounds are reversed, never selects.

Top module: `bank_cs_decoder`

## Requirements
- R1: After reset, bank 0 is enabled as ROM over 0xFFE0_0000 to 0xFFFF_FFFF, and banks 1 to 4 are disabled. All registered outputs read zero until the first lookup.
- R2: A lookup presented on one clock edge shows its result after that edge: `out_valid` is 1 and `cs_o` is one-hot on the selected bank. A bank matches when its start bound is at or below the address and the address is at or below its end bound.
- R3: The device kind of banks 1 to 4 is written through `wr_type` with the codes 0 SDRAM, 1 ROM, 2 SRAM and 3 peripheral, and it is reported on `sel_type` for a hit.
- R4: Bank 0 always reports kind 1 (ROM). The `wr_type` field of a write to bank 0 is ignored, while its bounds and enable bit are still written.
- R5: A bank whose enable bit is 0 never matches.
- R6: If no bank matches, `miss` is 1, `cs_o` is all zero, and `sel_bank` and `sel_type` are 0.
- R7: If several banks match, the lowest-numbered bank is selected and `cfg_err` is 1 for that result. Otherwise `cfg_err` is 0.
- R8: A bank whose end bound is below its start bound, or whose window is wider than 512 units of 1 MB, never matches. A window of exactly 512 units does match.
- R9: A write takes effect from the next cycle. A lookup in the same cycle as a write uses the old entry.
- R10: In a cycle with no lookup, the result after the edge has `out_valid` and `cs_o` at 0. `sel_bank`, `sel_type`, `miss` and `cfg_err` keep their last values, even when a write occurs.
- R11: A write whose `wr_bank` is 5 or above changes no bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one bank entry this cycle |
| wr_bank | input | 3 | Bank number to write |
| wr_lo | input | 12 | Start bound, address bits 31:20 |
| wr_hi | input | 12 | End bound, address bits 31:20 |
| wr_enable | input | 1 | Enable bit to store |
| wr_type | input | 2 | Device kind to store (0 SDRAM, 1 ROM, 2 SRAM, 3 peripheral) |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Address to decode |
| out_valid | output | 1 | Registered result belongs to a lookup |
| cs_o | output | 5 | One-hot chip selects |
| sel_bank | output | 3 | Selected bank number |
| sel_type | output | 2 | Device kind of selected bank |
| miss | output | 1 | No bank matched |
| cfg_err | output | 1 | More than one bank matched |

## Verification
The assertions assume that reset is held for at least one edge before any activity. They also assume that `wr_bank` and `wr_type` are always at known values, so bank indexing and the one-hot and hold properties stay meaningful. The bench drives every input from a negative clock edge and keeps the controls at zero outside its tasks. Writes that target bank numbers above 4 are issued on purpose, to show that they are ignored rather than to break these assumptions.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef enum logic [1:0] {
    DEV_SDRAM  = 2'd0,
    DEV_ROM    = 2'd1,
    DEV_SRAM   = 2'd2,
    DEV_PERIPH = 2'd3
  } dev_kind_t;
endpackage

// File: rtl/bsd_bank_table.sv
module bsd_bank_table #(
  parameter int NUM_BANKS = 5,
  parameter int BANK_W    = 3,
  parameter int BOUND_W   = 12,
  parameter logic [BOUND_W-1:0] BOOT_LO = '1,
  parameter logic [BOUND_W-1:0] BOOT_HI = '1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [BANK_W-1:0]                  wr_bank,
  input  logic [BOUND_W-1:0]                 wr_lo,
  input  logic [BOUND_W-1:0]                 wr_hi,
  input  logic                               wr_enable,
  input  logic [1:0]                         wr_type,
  output logic [NUM_BANKS-1:0][BOUND_W-1:0]  lo_o,
  output logic [NUM_BANKS-1:0][BOUND_W-1:0]  hi_o,
  output logic [NUM_BANKS-1:0]               en_o,
  output logic [NUM_BANKS-1:0][1:0]          type_o
);
  import bsd_pkg::*;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit_w;
    assign hit_w = wr_en && (wr_bank == BANK_W'(g));

    if (g == 0) begin : g_boot
      // boot bank: kind pinned to ROM, window and enable reprogrammable
      assign type_o[g] = DEV_ROM;
      always_ff @(posedge clk) begin
        if (rst) begin
          lo_o[g] <= BOOT_LO;
          hi_o[g] <= BOOT_HI;
          en_o[g] <= 1'b1;
        end else if (hit_w) begin
          lo_o[g] <= wr_lo;
          hi_o[g] <= wr_hi;
          en_o[g] <= wr_enable;
        end
      end
    end else begin : g_gen
      always_ff @(posedge clk) begin
        if (rst) begin
          lo_o[g]   <= '0;
          hi_o[g]   <= '0;
          en_o[g]   <= 1'b0;
          type_o[g] <= DEV_SDRAM;
        end else if (hit_w) begin
          lo_o[g]   <= wr_lo;
          hi_o[g]   <= wr_hi;
          en_o[g]   <= wr_enable;
          type_o[g] <= wr_type;
        end
      end
    end
  end
endmodule

// File: rtl/bsd_bank_match.sv
module bsd_bank_match #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 20,
  parameter int MAX_UNITS = 512,
  localparam int BOUND_W  = ADDR_W - GRAN_LOG2
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BOUND_W-1:0] lo,
  input  logic [BOUND_W-1:0] hi,
  input  logic               en,
  output logic               hit
);
  logic [BOUND_W:0]   span_m1;
  logic               legal;
  logic [ADDR_W-1:0]  lo_full, hi_full;

  always_comb begin
    span_m1 = {1'b0, hi} - {1'b0, lo};
    legal   = en && (hi >= lo) && (span_m1 < (BOUND_W+1)'(MAX_UNITS));
    lo_full = {lo, {GRAN_LOG2{1'b0}}};
    hi_full = {hi, {GRAN_LOG2{1'b1}}};
    hit     = legal && (addr >= lo_full) && (addr <= hi_full);
  end
endmodule

// File: rtl/bsd_prio_pick.sv
module bsd_prio_pick #(
  parameter int NUM_BANKS = 5,
  parameter int BANK_W    = 3
) (
  input  logic [NUM_BANKS-1:0]       hits,
  input  logic [NUM_BANKS-1:0][1:0]  kinds,
  output logic [NUM_BANKS-1:0]       onehot,
  output logic [BANK_W-1:0]          idx,
  output logic [1:0]                 kind,
  output logic                       none,
  output logic                       multi
);
  always_comb begin
    onehot = '0;
    idx    = '0;
    kind   = '0;
    // walk downward so the lowest-numbered hit is the last one kept
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        onehot = '0;
        onehot[i] = 1'b1;
        idx  = BANK_W'(i);
        kind = kinds[i];
      end
    end
    none  = (hits == '0);
    multi = ($countones(hits) > 1);
  end
endmodule

// File: rtl/bank_cs_decoder.sv
module bank_cs_decoder #(
  parameter int NUM_BANKS      = 5,
  parameter int ADDR_W         = 32,
  parameter int GRAN_LOG2      = 20,
  parameter int MAX_SPAN_LOG2  = 29,
  parameter logic [ADDR_W-1:0] BOOT_START = 32'hFFE0_0000,
  parameter logic [ADDR_W-1:0] BOOT_END   = 32'hFFFF_FFFF,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int BOUND_W   = ADDR_W - GRAN_LOG2,
  localparam int MAX_UNITS = 1 << (MAX_SPAN_LOG2 - GRAN_LOG2)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [BANK_W-1:0]     wr_bank,
  input  logic [BOUND_W-1:0]    wr_lo,
  input  logic [BOUND_W-1:0]    wr_hi,
  input  logic                  wr_enable,
  input  logic [1:0]            wr_type,
  input  logic                  lk_valid,
  input  logic [ADDR_W-1:0]     lk_addr,
  output logic                  out_valid,
  output logic [NUM_BANKS-1:0]  cs_o,
  output logic [BANK_W-1:0]     sel_bank,
  output logic [1:0]            sel_type,
  output logic                  miss,
  output logic                  cfg_err
);
  import bsd_pkg::*;

  localparam logic [BOUND_W-1:0] BOOT_LO = BOOT_START[ADDR_W-1:GRAN_LOG2];
  localparam logic [BOUND_W-1:0] BOOT_HI = BOOT_END[ADDR_W-1:GRAN_LOG2];

  logic [NUM_BANKS-1:0][BOUND_W-1:0] tb_lo, tb_hi;
  logic [NUM_BANKS-1:0]              tb_en;
  logic [NUM_BANKS-1:0][1:0]         tb_type;
  logic [NUM_BANKS-1:0]              hits;
  logic [NUM_BANKS-1:0]              pk_onehot;
  logic [BANK_W-1:0]                 pk_idx;
  logic [1:0]                        pk_kind;
  logic                              pk_none, pk_multi;

  bsd_bank_table #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .BOUND_W(BOUND_W),
    .BOOT_LO(BOOT_LO), .BOOT_HI(BOOT_HI)
  ) u_table (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_enable(wr_enable), .wr_type(wr_type),
    .lo_o(tb_lo), .hi_o(tb_hi), .en_o(tb_en), .type_o(tb_type)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
    bsd_bank_match #(
      .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .MAX_UNITS(MAX_UNITS)
    ) u_match (
      .addr(lk_addr), .lo(tb_lo[g]), .hi(tb_hi[g]), .en(tb_en[g]), .hit(hits[g])
    );
  end

  bsd_prio_pick #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_pick (
    .hits(hits), .kinds(tb_type), .onehot(pk_onehot), .idx(pk_idx),
    .kind(pk_kind), .none(pk_none), .multi(pk_multi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cs_o      <= '0;
      sel_bank  <= '0;
      sel_type  <= '0;
      miss      <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      out_valid <= lk_valid;
      if (lk_valid) begin
        cs_o     <= pk_onehot;
        sel_bank <= pk_idx;
        sel_type <= pk_kind;
        miss     <= pk_none;
        cfg_err  <= pk_multi;
      end else begin
        cs_o     <= '0;
      end
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_o)); // R2
  AST_CS_AGREES_BANK: assert property (@(posedge clk) disable iff (rst)
    (cs_o != '0) |-> (cs_o == (NUM_BANKS'(1) << sel_bank))); // R2
  AST_MISS_NO_CS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && miss) |-> (cs_o == '0 && sel_bank == '0)); // R6
  AST_BOOT_IS_ROM: assert property (@(posedge clk) disable iff (rst)
    cs_o[0] |-> (sel_type == DEV_ROM)); // R4
  AST_ERR_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !miss); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!lk_valid && !$past(rst)) |=> (cs_o == '0 && !out_valid &&
      $stable(sel_bank) && $stable(sel_type) && $stable(miss) && $stable(cfg_err))); // R10
endmodule

// File: tb/bank_cs_decoder_bench.sv
`timescale 1ns/1ps
module bank_cs_decoder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_enable, lk_valid;
  logic [2:0]  wr_bank;
  logic [11:0] wr_lo, wr_hi;
  logic [1:0]  wr_type;
  logic [31:0] lk_addr;
  logic        out_valid, miss, cfg_err;
  logic [4:0]  cs_o;
  logic [2:0]  sel_bank;
  logic [1:0]  sel_type;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bank_cs_decoder u_bank_cs_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .wr_enable(wr_enable), .wr_type(wr_type),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .out_valid(out_valid),
    .cs_o(cs_o), .sel_bank(sel_bank), .sel_type(sel_type),
    .miss(miss), .cfg_err(cfg_err)
  );

  // {addr, cs, bank, kind, miss, err}
  localparam logic [43:0] VEC [0:9] = '{
    {32'h0000_0000, 5'b00010, 3'd1, 2'd0, 1'b0, 1'b0},  // R2 R3 bank1 low edge
    {32'h0FFF_FFFF, 5'b00010, 3'd1, 2'd0, 1'b0, 1'b0},  // R2 bank1 high edge
    {32'h1000_0000, 5'b00100, 3'd2, 2'd2, 1'b0, 1'b0},  // R3 SRAM
    {32'h1300_0000, 5'b00100, 3'd2, 2'd2, 1'b0, 1'b1},  // R7 overlap 2/3
    {32'h1400_0000, 5'b01000, 3'd3, 2'd3, 1'b0, 1'b0},  // R3 peripheral
    {32'h1500_0000, 5'b00000, 3'd0, 2'd0, 1'b1, 1'b0},  // R6 gap
    {32'h9000_0000, 5'b00000, 3'd0, 2'd0, 1'b1, 1'b0},  // R8 too wide
    {32'hFFE0_0000, 5'b00001, 3'd0, 2'd1, 1'b0, 1'b0},  // R4 boot low
    {32'hFFFF_FFFF, 5'b00001, 3'd0, 2'd1, 1'b0, 1'b0},  // R4 boot high
    {32'hFFDF_FFFF, 5'b00000, 3'd0, 2'd0, 1'b1, 1'b0}   // R6 just below boot
  };

  task automatic check(string req, logic v, logic [4:0] cs, logic [2:0] b,
                       logic [1:0] k, logic m, logic e);
    n_chk++;
    if ({out_valid, cs_o, sel_bank, sel_type, miss, cfg_err} !== {v, cs, b, k, m, e}) begin
      n_bad++;
      $display("FAIL %s: got v=%b cs=%b bank=%0d kind=%0d miss=%b err=%b, exp v=%b cs=%b bank=%0d kind=%0d miss=%b err=%b",
               req, out_valid, cs_o, sel_bank, sel_type, miss, cfg_err, v, cs, b, k, m, e);
    end
  endtask

  task automatic wr(logic [2:0] b, logic [11:0] lo, logic [11:0] hi, logic en, logic [1:0] k);
    @(negedge clk);
    wr_en = 1; wr_bank = b; wr_lo = lo; wr_hi = hi; wr_enable = en; wr_type = k;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(logic [31:0] a);
    @(negedge clk);
    lk_valid = 1; lk_addr = a;
    @(negedge clk);
    lk_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1; wr_en = 0; wr_enable = 0; lk_valid = 0;
    wr_bank = 0; wr_lo = 0; wr_hi = 0; wr_type = 0; lk_addr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset outputs", 0, 5'b0, 0, 0, 0, 0);
    look(32'hFFF0_0000);
    check("R1 boot enabled", 1, 5'b00001, 0, 1, 0, 0);
    look(32'h0000_0000);
    check("R1 others disabled", 1, 5'b0, 0, 0, 1, 0);

    wr(3'd0, 12'hFFE, 12'hFFF, 1, 2'd2);  // R4 kind field ignored
    wr(3'd1, 12'h000, 12'h0FF, 1, 2'd0);
    wr(3'd2, 12'h100, 12'h13F, 1, 2'd2);
    wr(3'd3, 12'h130, 12'h14F, 1, 2'd3);
    wr(3'd4, 12'h800, 12'hA00, 1, 2'd1);  // R8 513 units
    for (int i = 0; i < 10; i++) begin
      look(VEC[i][43:12]);
      check($sformatf("R2 vector %0d", i), 1, VEC[i][11:7], VEC[i][6:4],
            VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end

    // R10: idle cycle with a write keeps fields, drops cs and valid
    look(32'h1000_0000);
    wr(3'd2, 12'h100, 12'h13F, 1, 2'd2);
    check("R10 idle hold", 0, 5'b0, 2, 2, 0, 0);

    // R8: reversed bounds never select, exact 512 units does
    wr(3'd4, 12'h900, 12'h800, 1, 2'd1);
    look(32'h8500_0000);
    check("R8 reversed", 1, 5'b0, 0, 0, 1, 0);
    wr(3'd4, 12'h800, 12'h9FF, 1, 2'd1);
    look(32'h9FF0_0000);
    check("R8 max span", 1, 5'b10000, 4, 1, 0, 0);

    // R5: disabling bank 1
    wr(3'd1, 12'h000, 12'h0FF, 0, 2'd0);
    look(32'h0000_1000);
    check("R5 disabled", 1, 5'b0, 0, 0, 1, 0);

    // R9: write and lookup in the same cycle
    @(negedge clk);
    wr_en = 1; wr_bank = 3'd1; wr_lo = 12'h000; wr_hi = 12'h0FF; wr_enable = 1; wr_type = 2'd3;
    lk_valid = 1; lk_addr = 32'h0000_1000;
    @(negedge clk);
    wr_en = 0; lk_valid = 0;
    check("R9 old entry", 1, 5'b0, 0, 0, 1, 0);
    look(32'h0000_1000);
    check("R9 new entry", 1, 5'b00010, 1, 3, 0, 0);

    // R11: out-of-range bank numbers write nothing
    wr(3'd5, 12'h500, 12'h5FF, 1, 2'd2);
    wr(3'd7, 12'h500, 12'h5FF, 1, 2'd2);
    look(32'h5000_0000);
    check("R11 no bank written", 1, 5'b0, 0, 0, 1, 0);

    // R4: bank 0 moved and re-typed still reports ROM
    wr(3'd0, 12'h600, 12'h600, 1, 2'd3);
    look(32'h600F_FFFF);
    check("R4 moved boot", 1, 5'b00001, 0, 1, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule